// File: doc/BRIEF.md
# Set-Associative Data Translation Buffer with Access Checks

This block translates the virtual addresses of loads and stores into physical addresses. It keeps a small set-associative table of page translations. Each entry holds a virtual tag, a physical page number, a valid bit, a cache-inhibit bit, a replacement age and four access-enable bits. The enables cover read and write for user mode and for supervisor mode. A normal lookup returns the physical address, the cache-inhibit attribute and a hit flag. It raises a page-fault pulse when the access is not allowed, or a miss pulse when no entry matches. Each lookup also ages the ways of the set it touched. There is no hardware refill: software fills entries through a write port. It reads the per-set ages back through an age view to choose a victim.

A second, side-effect-free probe port returns a translation without raising exceptions and without touching the ages. It answers zero on a miss or a permission failure. It updates the shared cache-inhibit output only when its through-cache input is set. When translation is switched off, both ports pass the address through unchanged. In that case, cache-inhibit follows the top address bit.

Results appear one clock after the request. A response state machine has five states. ST_IDLE presents nothing. ST_XLATE presents a translated lookup. ST_PASS presents a bypassed lookup. ST_PROBE presents a translated probe. ST_PROBE_PASS presents a bypassed probe. On every clock the machine moves from any state to one of these:
- ST_XLATE when a lookup arrives with translation on.
- ST_PASS when a lookup arrives with translation off.
- ST_PROBE when a probe arrives with translation on.
- ST_PROBE_PASS when a probe arrives with translation off.
- ST_IDLE when no request arrives.

Top module: `dtlb_core`

## Requirements
- R1: After reset every entry is invalid with age 0. All response outputs are 0, `nocache` is 0 and `age_view` reads 0.
- R2: With `xlat_on`=0, a lookup answers one cycle later with `rsp_valid`=1, `rsp_pa` = the virtual address, `rsp_hit`=0 and no exception pulse. `nocache` becomes bit 31 of the address.
- R3: The set index is va[PAGE_BITS +: SET_W] (va/page mod sets). The tag is the bits above it (va/(page*sets)). A hit needs the valid bit and an equal tag. On a hit, `rsp_pa` = {ppn, va[PAGE_BITS-1:0]} and `nocache` takes the entry's inhibit bit.
- R4: The permission bits are bit0 user-read, bit1 user-write, bit2 supervisor-read and bit3 supervisor-write. The bit used is index {super, write}. When it is 0 on a hit, `rsp_fault` pulses with `exc_va` = va, and the translation is still presented.
- R5: A lookup miss pulses `rsp_miss` with `exc_va` = va, `rsp_pa`=0 and `rsp_hit`=0, and leaves `nocache` unchanged.
- R6: A translated lookup hit sets the hit way's age to 2^AGE_W-1 and decrements every other nonzero age in that set. A miss changes no age.
- R7: A probe answers one cycle later on `prb_rsp_valid`. The answer is the translation on a permitted hit, 0 on a miss or refused access, and the address itself when translation is off. A probe never raises `rsp_fault`/`rsp_miss` and never changes an age.
- R8: A probe changes `nocache` only when `prb_thru`=1 and it produces a translation (entry bit) or a bypass (address bit 31). Otherwise `nocache` holds.
- R9: A write on `wr_en` stores valid, tag, ppn, permissions and inhibit into (`wr_way`, `wr_set`) and clears that entry's age. It is seen by lookups from the next cycle. It wins over a same-cycle age update of the same entry.
- R10: When several valid ways of a set carry the same tag, the highest-numbered way supplies the translation and receives the age update.
- R11: Exception and valid outputs are single-cycle pulses tied to one request. A lookup and a probe are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_on | input | 1 | Translation enabled (0 = pass-through) |
| req_valid | input | 1 | Lookup request |
| req_va | input | ADDR_W | Lookup virtual address |
| req_write | input | 1 | Lookup is a store |
| req_super | input | 1 | Lookup in supervisor mode |
| prb_valid | input | 1 | Probe request |
| prb_va | input | ADDR_W | Probe virtual address |
| prb_write | input | 1 | Probe checks write permission |
| prb_super | input | 1 | Probe in supervisor mode |
| prb_thru | input | 1 | Probe may update cache-inhibit |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | SET_W | Set to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_tag | input | TAG_W | Virtual tag to store |
| wr_ppn | input | PPN_W | Physical page number to store |
| wr_perm | input | 4 | Permission bits (see R4) |
| wr_nocache | input | 1 | Cache-inhibit bit to store |
| age_set | input | SET_W | Set whose ages are shown |
| age_view | output | NWAYS*AGE_W | Ages of that set, way w at [w*AGE_W +: AGE_W] |
| rsp_valid | output | 1 | Lookup response present |
| rsp_pa | output | ADDR_W | Lookup physical address |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Page-fault pulse |
| rsp_miss | output | 1 | Translation-miss pulse |
| exc_va | output | ADDR_W | Faulting address while a pulse is high, else 0 |
| nocache | output | 1 | Current cache-inhibit attribute |
| prb_rsp_valid | output | 1 | Probe response present |
| prb_pa | output | ADDR_W | Probe answer |

## Verification
The bench targets the following corner cases. A lookup that faults must still present its translation and must age its set. A design that checked permissions before ageing would leave the ages stale. Several ways holding one tag must resolve to the highest way; a priority encoder built the wrong way round would return another page number. Probes must leave ages untouched and must leave `nocache` alone unless `prb_thru` is set and the probe succeeds. A design that shared the lookup side effects would show changed ages in `age_view` or a flipped `nocache`. A write racing a hit on the same entry must leave age 0. Choosing the wrong order would show the maximum age instead.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    // Response state: what the outputs present in the current cycle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE,
        ST_PASS,
        ST_PROBE,
        ST_PROBE_PASS
    } dtlb_state_e;

    localparam int PERM_W = 4;

    // Permission bit positions; index = {supervisor, write}.
    localparam int PERM_USER_RD  = 0;
    localparam int PERM_USER_WR  = 1;
    localparam int PERM_SUPER_RD = 2;
    localparam int PERM_SUPER_WR = 3;

    function automatic logic access_allowed(
        input logic [PERM_W-1:0] perm,
        input logic              sup,
        input logic              wr
    );
        return perm[{sup, wr}];
    endfunction

endpackage

// File: rtl/dtlb_way_store.sv
module dtlb_way_store #(
    parameter int SET_W = 2,
    parameter int TAG_W = 17,
    parameter int PPN_W = 19,
    parameter int AGE_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             lk_set,
    output logic                         lk_vld,
    output logic [TAG_W-1:0]             lk_tag,
    output logic [PPN_W-1:0]             lk_ppn,
    output logic [dtlb_pkg::PERM_W-1:0]  lk_perm,
    output logic                         lk_ci,
    input  logic [SET_W-1:0]             ag_set,
    output logic [AGE_W-1:0]             ag_age,
    input  logic                         age_upd,
    input  logic                         age_is_hit,
    input  logic                         wr_sel,
    input  logic [SET_W-1:0]             wr_set,
    input  logic                         wr_vld,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [PPN_W-1:0]             wr_ppn,
    input  logic [dtlb_pkg::PERM_W-1:0]  wr_perm,
    input  logic                         wr_ci
);
    localparam int SETS = 1 << SET_W;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [SETS-1:0]                        vld_q;
    logic [SETS-1:0][TAG_W-1:0]             tag_q;
    logic [SETS-1:0][PPN_W-1:0]             ppn_q;
    logic [SETS-1:0][dtlb_pkg::PERM_W-1:0]  perm_q;
    logic [SETS-1:0]                        ci_q;
    logic [SETS-1:0][AGE_W-1:0]             age_q;

    assign lk_vld  = vld_q[lk_set];
    assign lk_tag  = tag_q[lk_set];
    assign lk_ppn  = ppn_q[lk_set];
    assign lk_perm = perm_q[lk_set];
    assign lk_ci   = ci_q[lk_set];
    assign ag_age  = age_q[ag_set];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            tag_q  <= '0;
            ppn_q  <= '0;
            perm_q <= '0;
            ci_q   <= '0;
            age_q  <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (wr_sel && wr_set == SET_W'(s)) begin
                    vld_q[s]  <= wr_vld;
                    tag_q[s]  <= wr_tag;
                    ppn_q[s]  <= wr_ppn;
                    perm_q[s] <= wr_perm;
                    ci_q[s]   <= wr_ci;
                    age_q[s]  <= '0;
                end else if (age_upd && lk_set == SET_W'(s)) begin
                    if (age_is_hit)
                        age_q[s] <= AGE_MAX;
                    else if (age_q[s] != '0)
                        age_q[s] <= age_q[s] - 1'b1;
                end
            end
        end
    end

    // R6: the hit way ends at the top age unless a write replaced it.
    p_hit_age_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_upd && age_is_hit && !(wr_sel && wr_set == lk_set))
        |=> (age_q[$past(lk_set)] == AGE_MAX));

    // R7: without a lookup hit or a write no age moves (probes included).
    p_age_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!age_upd && !wr_sel) |=> $stable(age_q));

    // R9: a written entry starts with age zero.
    p_write_clears_age_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (age_q[$past(wr_set)] == '0));

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match #(
    parameter int NWAYS = 4,
    parameter int WAY_W = 2,
    parameter int TAG_W = 17,
    parameter int PPN_W = 19
) (
    input  logic [NWAYS-1:0]                        way_vld,
    input  logic [NWAYS-1:0][TAG_W-1:0]             way_tag,
    input  logic [NWAYS-1:0][PPN_W-1:0]             way_ppn,
    input  logic [NWAYS-1:0][dtlb_pkg::PERM_W-1:0]  way_perm,
    input  logic [NWAYS-1:0]                        way_ci,
    input  logic [TAG_W-1:0]                        va_tag,
    output logic                                    hit,
    output logic [WAY_W-1:0]                        hit_way,
    output logic [PPN_W-1:0]                        sel_ppn,
    output logic [dtlb_pkg::PERM_W-1:0]             sel_perm,
    output logic                                    sel_ci
);
    logic [NWAYS-1:0] match;

    for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
        assign match[g] = way_vld[g] && (way_tag[g] == va_tag);
    end

    // Ascending scan: the highest matching way is the one kept (R10).
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        sel_ppn  = '0;
        sel_perm = '0;
        sel_ci   = 1'b0;
        for (int w = 0; w < NWAYS; w++) begin
            if (match[w]) begin
                hit      = 1'b1;
                hit_way  = WAY_W'(w);
                sel_ppn  = way_ppn[w];
                sel_perm = way_perm[w];
                sel_ci   = way_ci[w];
            end
        end
    end

endmodule

// File: rtl/dtlb_core.sv
module dtlb_core #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SET_W     = 2,
    parameter int NWAYS     = 4,
    parameter int AGE_W     = 2,
    localparam int TAG_W    = ADDR_W - PAGE_BITS - SET_W,
    localparam int PPN_W    = ADDR_W - PAGE_BITS,
    localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xlat_on,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_va,
    input  logic                   req_write,
    input  logic                   req_super,
    input  logic                   prb_valid,
    input  logic [ADDR_W-1:0]      prb_va,
    input  logic                   prb_write,
    input  logic                   prb_super,
    input  logic                   prb_thru,
    input  logic                   wr_en,
    input  logic [WAY_W-1:0]       wr_way,
    input  logic [SET_W-1:0]       wr_set,
    input  logic                   wr_valid,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic [PPN_W-1:0]       wr_ppn,
    input  logic [3:0]             wr_perm,
    input  logic                   wr_nocache,
    input  logic [SET_W-1:0]       age_set,
    output logic [NWAYS*AGE_W-1:0] age_view,
    output logic                   rsp_valid,
    output logic [ADDR_W-1:0]      rsp_pa,
    output logic                   rsp_hit,
    output logic                   rsp_fault,
    output logic                   rsp_miss,
    output logic [ADDR_W-1:0]      exc_va,
    output logic                   nocache,
    output logic                   prb_rsp_valid,
    output logic [ADDR_W-1:0]      prb_pa
);
    import dtlb_pkg::*;

    // Shared lookup path: the probe borrows it in its own cycle.
    logic [ADDR_W-1:0] lk_va;
    logic              lk_write, lk_super;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;

    assign lk_va    = prb_valid ? prb_va    : req_va;
    assign lk_write = prb_valid ? prb_write : req_write;
    assign lk_super = prb_valid ? prb_super : req_super;
    assign lk_set   = lk_va[PAGE_BITS +: SET_W];
    assign lk_tag   = lk_va[ADDR_W-1 -: TAG_W];

    logic [NWAYS-1:0]                w_vld, w_ci;
    logic [NWAYS-1:0][TAG_W-1:0]     w_tag;
    logic [NWAYS-1:0][PPN_W-1:0]     w_ppn;
    logic [NWAYS-1:0][PERM_W-1:0]    w_perm;
    logic [NWAYS-1:0][AGE_W-1:0]     w_age;

    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [PPN_W-1:0]  sel_ppn;
    logic [PERM_W-1:0] sel_perm;
    logic              sel_ci;
    logic              age_upd;

    assign age_upd = req_valid && xlat_on && hit;

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        dtlb_way_store #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .PPN_W (PPN_W),
            .AGE_W (AGE_W)
        ) store_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_set     (lk_set),
            .lk_vld     (w_vld[g]),
            .lk_tag     (w_tag[g]),
            .lk_ppn     (w_ppn[g]),
            .lk_perm    (w_perm[g]),
            .lk_ci      (w_ci[g]),
            .ag_set     (age_set),
            .ag_age     (w_age[g]),
            .age_upd    (age_upd),
            .age_is_hit (hit_way == WAY_W'(g)),
            .wr_sel     (wr_en && wr_way == WAY_W'(g)),
            .wr_set     (wr_set),
            .wr_vld     (wr_valid),
            .wr_tag     (wr_tag),
            .wr_ppn     (wr_ppn),
            .wr_perm    (wr_perm),
            .wr_ci      (wr_nocache)
        );
        assign age_view[g*AGE_W +: AGE_W] = w_age[g];
    end

    dtlb_match #(
        .NWAYS (NWAYS),
        .WAY_W (WAY_W),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) match_i (
        .way_vld  (w_vld),
        .way_tag  (w_tag),
        .way_ppn  (w_ppn),
        .way_perm (w_perm),
        .way_ci   (w_ci),
        .va_tag   (lk_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .sel_ppn  (sel_ppn),
        .sel_perm (sel_perm),
        .sel_ci   (sel_ci)
    );

    logic perm_ok;
    assign perm_ok = access_allowed(sel_perm, lk_super, lk_write);

    // ---------------- response state machine ----------------
    dtlb_state_e state_q, state_d;

    always_comb begin
        if (req_valid)
            state_d = xlat_on ? ST_XLATE : ST_PASS;
        else if (prb_valid)
            state_d = xlat_on ? ST_PROBE : ST_PROBE_PASS;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Captured lookup result and the persistent cache-inhibit attribute.
    logic [ADDR_W-1:0] va_q, pa_q;
    logic              hit_q, ok_q, nc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q  <= '0;
            pa_q  <= '0;
            hit_q <= 1'b0;
            ok_q  <= 1'b0;
            nc_q  <= 1'b0;
        end else begin
            va_q  <= lk_va;
            pa_q  <= {sel_ppn, lk_va[PAGE_BITS-1:0]};
            hit_q <= hit;
            ok_q  <= perm_ok;
            if (req_valid) begin
                if (!xlat_on)
                    nc_q <= lk_va[ADDR_W-1];
                else if (hit)
                    nc_q <= sel_ci;
            end else if (prb_valid && prb_thru) begin
                if (!xlat_on)
                    nc_q <= lk_va[ADDR_W-1];
                else if (hit && perm_ok)
                    nc_q <= sel_ci;
            end
        end
    end

    always_comb begin
        rsp_valid     = 1'b0;
        rsp_pa        = '0;
        rsp_hit       = 1'b0;
        rsp_fault     = 1'b0;
        rsp_miss      = 1'b0;
        exc_va        = '0;
        prb_rsp_valid = 1'b0;
        prb_pa        = '0;
        nocache       = nc_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_XLATE: begin
                rsp_valid = 1'b1;
                rsp_hit   = hit_q;
                rsp_pa    = hit_q ? pa_q : '0;
                rsp_fault = hit_q && !ok_q;
                rsp_miss  = !hit_q;
                exc_va    = (hit_q && ok_q) ? '0 : va_q;
            end
            ST_PASS: begin
                rsp_valid = 1'b1;
                rsp_pa    = va_q;
            end
            ST_PROBE: begin
                prb_rsp_valid = 1'b1;
                prb_pa        = (hit_q && ok_q) ? pa_q : '0;
            end
            ST_PROBE_PASS: begin
                prb_rsp_valid = 1'b1;
                prb_pa        = va_q;
            end
            default: ;
        endcase
    end

    // R11: one request source per cycle.
    p_single_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && prb_valid));

    // R11: an exception pulse always follows a translated lookup.
    p_exc_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_miss) |-> $past(req_valid && xlat_on));

    // R5: a miss never alters the cache-inhibit attribute.
    p_miss_keeps_nc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> $stable(nocache));

    // R8: a probe without through-cache leaves cache-inhibit alone.
    p_probe_nc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prb_valid && !prb_thru) |-> $stable(nocache));

    // R2: pass-through returns the address unchanged.
    p_pass_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !xlat_on) |-> (rsp_pa == $past(req_va)));

    // R5: exceptions are exclusive.
    p_fault_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault && rsp_miss));

endmodule

// File: tb/dtlb_core_tb_top.sv
module dtlb_core_tb_top;
    localparam int AW   = 32;
    localparam int PB   = 13;
    localparam int SW   = 2;
    localparam int NW   = 4;
    localparam int AGW  = 2;
    localparam int SETS = 1 << SW;
    localparam int TW   = AW - PB - SW;
    localparam int PW   = AW - PB;
    localparam int WW   = 2;
    localparam int AMAX = (1 << AGW) - 1;
    localparam logic [31:0] PAGE = 32'd1 << PB;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, xlat_on;
    logic req_valid, req_write, req_super;
    logic [AW-1:0] req_va;
    logic prb_valid, prb_write, prb_super, prb_thru;
    logic [AW-1:0] prb_va;
    logic wr_en, wr_valid, wr_nocache;
    logic [WW-1:0] wr_way;
    logic [SW-1:0] wr_set, age_set;
    logic [TW-1:0] wr_tag;
    logic [PW-1:0] wr_ppn;
    logic [3:0] wr_perm;
    logic [NW*AGW-1:0] age_view;
    logic rsp_valid, rsp_hit, rsp_fault, rsp_miss, nocache, prb_rsp_valid;
    logic [AW-1:0] rsp_pa, exc_va, prb_pa;

    dtlb_core dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_on(xlat_on),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_super(req_super),
        .prb_valid(prb_valid), .prb_va(prb_va), .prb_write(prb_write), .prb_super(prb_super),
        .prb_thru(prb_thru),
        .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_valid(wr_valid), .wr_tag(wr_tag),
        .wr_ppn(wr_ppn), .wr_perm(wr_perm), .wr_nocache(wr_nocache),
        .age_set(age_set), .age_view(age_view),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_miss(rsp_miss), .exc_va(exc_va), .nocache(nocache),
        .prb_rsp_valid(prb_rsp_valid), .prb_pa(prb_pa)
    );

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    // Behavioural reference state
    bit          m_vld  [NW][SETS];
    logic [31:0] m_tag  [NW][SETS];
    logic [31:0] m_ppn  [NW][SETS];
    logic [3:0]  m_perm [NW][SETS];
    bit          m_ci   [NW][SETS];
    int          m_age  [NW][SETS];

    logic e_rv, e_hit, e_fault, e_miss, e_nc, e_prv;
    logic [31:0] e_pa, e_exc, e_ppa;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) %s: got %h expected %h", req, phase, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(int tag, int set, int off);
        return (32'(tag) << (PB + SW)) | (32'(set) << PB) | (32'(off) & (PAGE - 1));
    endfunction

    task automatic model_reset();
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < SETS; s++) begin
                m_vld[w][s] = 0; m_tag[w][s] = 0; m_ppn[w][s] = 0;
                m_perm[w][s] = 0; m_ci[w][s] = 0; m_age[w][s] = 0;
            end
        e_rv = 0; e_hit = 0; e_fault = 0; e_miss = 0; e_nc = 0; e_prv = 0;
        e_pa = 0; e_exc = 0; e_ppa = 0;
    endtask

    function automatic int find_way(logic [31:0] va);
        int set = int'((va / PAGE) % SETS);
        logic [31:0] tg = va / (PAGE * SETS);
        int way = -1;
        for (int w = 0; w < NW; w++)
            if (m_vld[w][set] && m_tag[w][set] == tg) way = w;
        return way;
    endfunction

    task automatic model_eval();
        int set, way;
        bit ok;
        e_rv = 0; e_hit = 0; e_fault = 0; e_miss = 0; e_pa = 0; e_exc = 0;
        e_prv = 0; e_ppa = 0;
        if (req_valid) begin
            e_rv = 1;
            if (!xlat_on) begin
                e_pa = req_va; e_nc = req_va[31];
            end else begin
                set = int'((req_va / PAGE) % SETS);
                way = find_way(req_va);
                if (way >= 0) begin
                    e_hit = 1;
                    e_pa  = m_ppn[way][set] * PAGE + req_va % PAGE;
                    ok = m_perm[way][set][int'(req_super) * 2 + int'(req_write)];
                    if (!ok) begin e_fault = 1; e_exc = req_va; end
                    e_nc = m_ci[way][set];
                    for (int w = 0; w < NW; w++)
                        if (w == way) m_age[w][set] = AMAX;
                        else if (m_age[w][set] > 0) m_age[w][set]--;
                end else begin
                    e_miss = 1; e_exc = req_va;
                end
            end
        end else if (prb_valid) begin
            e_prv = 1;
            if (!xlat_on) begin
                e_ppa = prb_va;
                if (prb_thru) e_nc = prb_va[31];
            end else begin
                set = int'((prb_va / PAGE) % SETS);
                way = find_way(prb_va);
                if (way >= 0 && m_perm[way][set][int'(prb_super) * 2 + int'(prb_write)]) begin
                    e_ppa = m_ppn[way][set] * PAGE + prb_va % PAGE;
                    if (prb_thru) e_nc = m_ci[way][set];
                end
            end
        end
        if (wr_en) begin
            m_vld[wr_way][wr_set]  = wr_valid;
            m_tag[wr_way][wr_set]  = 32'(wr_tag);
            m_ppn[wr_way][wr_set]  = 32'(wr_ppn);
            m_perm[wr_way][wr_set] = wr_perm;
            m_ci[wr_way][wr_set]   = wr_nocache;
            m_age[wr_way][wr_set]  = 0;
        end
    endtask

    task automatic compare_all();
        logic [NW*AGW-1:0] ev;
        for (int w = 0; w < NW; w++) ev[w*AGW +: AGW] = AGW'(m_age[w][age_set]);
        chk("R11", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk("R3", "rsp_pa", 64'(rsp_pa), 64'(e_pa));
        chk("R3", "rsp_hit", 64'(rsp_hit), 64'(e_hit));
        chk("R4", "rsp_fault", 64'(rsp_fault), 64'(e_fault));
        chk("R5", "rsp_miss", 64'(rsp_miss), 64'(e_miss));
        chk("R5", "exc_va", 64'(exc_va), 64'(e_exc));
        chk("R8", "nocache", 64'(nocache), 64'(e_nc));
        chk("R7", "prb_rsp_valid", 64'(prb_rsp_valid), 64'(e_prv));
        chk("R7", "prb_pa", 64'(prb_pa), 64'(e_ppa));
        chk("R6", "age_view", 64'(age_view), 64'(ev));
    endtask

    task automatic clear_inputs();
        req_valid = 0; prb_valid = 0; wr_en = 0;
    endtask

    task automatic tick();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clear_inputs();
    endtask

    task automatic lookup(logic [31:0] va, bit wr, bit sup);
        req_valid = 1; req_va = va; req_write = wr; req_super = sup;
        tick();
    endtask

    task automatic probe(logic [31:0] va, bit wr, bit sup, bit thru);
        prb_valid = 1; prb_va = va; prb_write = wr; prb_super = sup; prb_thru = thru;
        tick();
    endtask

    task automatic set_write(int way, int set, bit v, int tag, int ppn, logic [3:0] perm, bit ci);
        wr_en = 1; wr_way = WW'(way); wr_set = SW'(set); wr_valid = v;
        wr_tag = TW'(tag); wr_ppn = PW'(ppn); wr_perm = perm; wr_nocache = ci;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 0; xlat_on = 0; age_set = 0;
        req_va = 0; req_write = 0; req_super = 0;
        prb_va = 0; prb_write = 0; prb_super = 0; prb_thru = 0;
        wr_way = 0; wr_set = 0; wr_valid = 0; wr_tag = 0; wr_ppn = 0; wr_perm = 0; wr_nocache = 0;
        clear_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the outputs
        phase = "R1";
        compare_all();
        for (int s = 0; s < SETS; s++) begin
            age_set = SW'(s);
            #1 chk("R1", "age_view after reset", 64'(age_view), 64'd0);
        end
        age_set = 1;

        // R2: pass-through with translation off
        phase = "R2";
        lookup(32'h1234_5678, 0, 0);
        lookup(32'h8000_0010, 1, 1);
        lookup(32'h7fff_ffff, 0, 1);

        // R9: fill entries
        phase = "R9";
        set_write(0, 1, 1, 5, 32'h111, 4'b0101, 0); tick();
        set_write(1, 1, 1, 6, 32'h222, 4'b1111, 1); tick();
        set_write(3, 2, 1, 7, 32'h333, 4'b1010, 0); tick();
        xlat_on = 1;

        // R3 / R4: hits and permission selection
        phase = "R3";
        lookup(mkva(5, 1, 12'h0ab), 0, 0);
        lookup(mkva(6, 1, 13'h1fff), 1, 1);
        phase = "R4";
        lookup(mkva(5, 1, 4), 1, 0);   // user write refused
        lookup(mkva(5, 1, 8), 1, 1);   // supervisor write refused
        lookup(mkva(5, 1, 8), 0, 1);   // supervisor read allowed
        lookup(mkva(7, 2, 3), 0, 0);   // user read refused
        lookup(mkva(7, 2, 3), 1, 0);   // user write allowed

        // R5: misses (wrong tag, wrong set)
        phase = "R5";
        lookup(mkva(9, 1, 0), 0, 0);
        lookup(mkva(5, 3, 0), 1, 1);

        // R6: ageing in set 1
        phase = "R6";
        for (int i = 0; i < 6; i++) lookup(mkva((i % 2) ? 6 : 5, 1, i), 0, 1);
        lookup(mkva(6, 1, 0), 0, 1);
        lookup(mkva(6, 1, 0), 0, 1);

        // R7 / R8: probes
        phase = "R7";
        probe(mkva(5, 1, 16), 0, 0, 0);
        probe(mkva(6, 1, 16), 0, 0, 1);
        probe(mkva(5, 1, 16), 1, 0, 1);   // refused: zero, ci held
        probe(mkva(9, 0, 16), 0, 1, 1);   // miss: zero
        phase = "R8";
        probe(mkva(5, 1, 20), 0, 0, 1);
        probe(mkva(6, 1, 20), 0, 0, 0);
        xlat_on = 0;
        probe(32'h9000_0000, 0, 0, 0);
        probe(32'h9000_0000, 0, 0, 1);
        probe(32'h1000_0000, 1, 1, 1);
        xlat_on = 1;

        // R10: duplicate tag in way 2 and way 0 of set 1
        phase = "R10";
        set_write(2, 1, 1, 5, 32'h444, 4'b1111, 1); tick();
        lookup(mkva(5, 1, 1), 1, 0);
        probe(mkva(5, 1, 2), 1, 1, 1);

        // R9: write racing a hit on the same entry
        phase = "R9";
        set_write(2, 1, 1, 5, 32'h555, 4'b0001, 0);
        req_valid = 1; req_va = mkva(5, 1, 7); req_write = 0; req_super = 0;
        tick();
        lookup(mkva(5, 1, 7), 0, 0);
        set_write(2, 1, 0, 5, 32'h555, 4'b0001, 0); tick();
        lookup(mkva(5, 1, 7), 0, 0);

        // R11: idle cycles after a pulse
        phase = "R11";
        lookup(mkva(30, 0, 0), 0, 0);
        tick();
        tick();

        // Mixed traffic
        phase = "R3";
        for (int i = 0; i < 600; i++) begin
            int op  = int'($urandom_range(0, 9));
            int tg  = int'($urandom_range(1, 3));
            int st  = int'($urandom_range(0, SETS - 1));
            logic [31:0] va = mkva(tg, st, int'($urandom_range(0, 8191)));
            if ($urandom_range(0, 3) == 0) va[31] = 1'b1;
            xlat_on = ($urandom_range(0, 7) != 0);
            age_set = SW'($urandom_range(0, SETS - 1));
            if (op < 4) begin
                req_valid = 1; req_va = va;
                req_write = 1'($urandom_range(0, 1)); req_super = 1'($urandom_range(0, 1));
            end else if (op < 7) begin
                prb_valid = 1; prb_va = va;
                prb_write = 1'($urandom_range(0, 1)); prb_super = 1'($urandom_range(0, 1));
                prb_thru = 1'($urandom_range(0, 1));
            end
            if (op >= 6 || $urandom_range(0, 5) == 0)
                set_write(int'($urandom_range(0, NW - 1)), int'($urandom_range(0, SETS - 1)),
                          1'($urandom_range(0, 4) != 0), int'($urandom_range(1, 3)),
                          int'($urandom_range(0, 32'h7ffff)), 4'($urandom_range(0, 15)),
                          1'($urandom_range(0, 1)));
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule